// File: doc/BRIEF.md
# Serial Audio Word Transmitter

This block turns parallel PCM words into a serial data stream, most significant bit first, timed by an external bit clock and framed by an external frame sync. Both the bit clock and the frame sync arrive as plain inputs. The block samples them in the system clock domain. The chosen edge of the bit clock, called the active edge, is where the block launches each bit and samples the frame sync. A frame holds a programmable number of words, each of a programmable encoded length, sent back to back. The first word starts either on the active edge that sees the frame sync rise, or one bit slot after it.

Software or a DMA engine feeds words through a single holding register with a valid/ready handshake. A request output can follow one of four events so that the feeder knows when to supply data. Unexpected frame syncs are detected and latched, unless the block is told to ignore them. A slot that starts with no fresh word repeats the last word and latches an underrun. Dropping the transmit enable puts the block back into its off state and clears its flags.

The state machine has four states:
- OFF: transmit enable is low.
- WAIT: enabled and waiting for a frame sync.
- DELAY: a single zero bit slot before the first word.
- SHIFT: word bits are being sent.

It has these transitions:
- enable: OFF to WAIT.
- start: WAIT or SHIFT to DELAY or SHIFT, on a frame sync.
- first-load: DELAY to SHIFT.
- finish: SHIFT to WAIT when the frame has ended and no sync is present.
- abort: DELAY or SHIFT to WAIT on an unexpected sync.
- disable: any state to OFF.

Top module: `sat_tx`

## Requirements
- R1: `cfg_wlen` selects the word length: 0=8, 1=12, 2=16, 3=20, 4=24, 5=32 bits. Only the low length bits of `in_data` are sent, highest of them first, and the upper bits are ignored.
- R2: With `cfg_delay`=0, the MSB of the first word is launched on the active edge where the frame sync is seen rising. With `cfg_delay`=1, that edge launches one zero bit, and the MSB follows on the next active edge.
- R3: With `cfg_clk_pol`=0, the active edge is the rising edge of `bclk`. With `cfg_clk_pol`=1, it is the falling edge. `sdata` and `fsync` sampling act only on active edges.
- R4: A frame carries `cfg_frame_len`+1 words with no gap between them. After the last bit slot ends, `sdata` is 0 until the next frame sync.
- R5: `in_ready` is high when `tx_en` is high and the holding register is empty. A word is taken when `in_valid` and `in_ready` are both high, and the holding register empties when a slot starts and loads it.
- R6: If the holding register is empty when a slot starts, the previous word is sent again and `underrun` is set. `underrun` stays set until `tx_en` falls.
- R7: A rising frame sync seen in DELAY, or in SHIFT before the final bit slot ends, is unexpected when `cfg_ign_fs`=0. It sets the sticky `sync_err`, forces `sdata` to 0 and abandons the frame, and the block waits for the next sync.
- R8: With `cfg_ign_fs`=1, an unexpected frame sync is ignored. The frame continues unchanged and `sync_err` stays low.
- R9: While `tx_en` is low, the block sits in OFF and ignores `bclk`, `fsync` and `in_valid`. One cycle after `tx_en` falls, `sdata`, `sync_err` and `underrun` are 0 and the holding register is empty.
- R10: `cfg_req_mode` selects what drives `tx_req`:
  - 0: `tx_req` equals `in_ready`.
  - 1: a one-cycle pulse each time a slot loads a word.
  - 2: a one-cycle pulse at each frame start.
  - 3: `tx_req` equals `sync_err`.
- R11: A frame sync on the active edge that ends a frame's final bit slot starts the next frame at once, with no sync error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low holds the block in OFF |
| cfg_wlen | input | 3 | Encoded word length |
| cfg_delay | input | 1 | Data delay after frame sync: 0 or 1 bit |
| cfg_clk_pol | input | 1 | Active bit clock edge: 0 rising, 1 falling |
| cfg_frame_len | input | FRLEN_W | Words per frame minus one |
| cfg_ign_fs | input | 1 | Ignore unexpected frame syncs |
| cfg_req_mode | input | 2 | Event selected onto tx_req |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync, active high |
| in_data | input | 32 | Word to send, right-aligned |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Holding register can take a word |
| sdata | output | 1 | Serial data |
| tx_req | output | 1 | Data request per cfg_req_mode |
| sync_err | output | 1 | Sticky unexpected frame sync flag |
| underrun | output | 1 | Sticky repeated word flag |

## Verification
The bench builds the block with the default FRLEN_W of 3, so frames of one to eight words are possible. Its vector table sends mono, stereo, three-word and four-word frames that together cover all six word lengths, both delays and both clock edges. Every vector uses data with the bits above the word length set, so a leaking upper bit shows up as a wrong serial bit. Directed runs cover the rest: an unfed slot, an early sync with and without the ignore bit, a frame that follows another with no gap, each request mode, and words offered while the block is disabled.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int WORD_MAX = 32;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_SHIFT = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        REQ_EMPTY   = 2'd0,
        REQ_SLOT    = 2'd1,
        REQ_FRAME   = 2'd2,
        REQ_SYNCERR = 2'd3
    } req_mode_e;

    // Decode of the word length field into a bit count.
    function automatic logic [5:0] word_bits(input logic [2:0] code);
        logic [5:0] n;
        case (code)
            3'd0:    n = 6'd8;
            3'd1:    n = 6'd12;
            3'd2:    n = 6'd16;
            3'd3:    n = 6'd20;
            3'd4:    n = 6'd24;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sat_bit_timing.sv
module sat_bit_timing (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clk_pol,
    input  logic bclk,
    input  logic fsync,
    output logic tick,
    output logic fs_start
);

    logic bclk_q;
    logic fs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
        end else begin
            bclk_q <= bclk;
        end
    end

    // Active edge: rising for polarity 0, falling for polarity 1.
    assign tick = enable && (clk_pol ? (!bclk && bclk_q) : (bclk && !bclk_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_prev <= 1'b0;
        end else if (!enable) begin
            fs_prev <= 1'b0;
        end else if (tick) begin
            fs_prev <= fsync;
        end
    end

    assign fs_start = tick && fsync && !fs_prev;

endmodule

// File: rtl/sat_hold_reg.sv
module sat_hold_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              take,
    output logic              in_ready,
    output logic              full,
    output logic [WORD_W-1:0] data
);

    assign in_ready = enable && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (!enable) begin
            full <= 1'b0;
        end else if (take && full) begin
            full <= 1'b0;
        end else if (in_valid && !full) begin
            full <= 1'b1;
            data <= in_data;
        end
    end

endmodule

// File: rtl/sat_tx_fsm.sv
module sat_tx_fsm
    import sat_pkg::*;
#(
    parameter int FRLEN_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [2:0]          wlen_code,
    input  logic                delay_on,
    input  logic [FRLEN_W-1:0]  frame_len,
    input  logic                ign_fs,
    input  logic                tick,
    input  logic                fs_start,
    input  logic                hold_full,
    input  logic [WORD_MAX-1:0] hold_data,
    output logic                take,
    output logic                sdata,
    output logic                sync_err,
    output logic                underrun,
    output logic                slot_pulse,
    output logic                frame_pulse
);

    localparam int BIT_W = $clog2(WORD_MAX);

    tx_state_e             state_q, state_n;
    logic [BIT_W-1:0]      bit_cnt, msb_idx, shift_idx;
    logic [FRLEN_W-1:0]    word_cnt;
    logic [WORD_MAX-1:0]   cur_word, next_word;
    logic start_frame, load_word, first_load, do_shift, go_quiet, abort_frame;
    logic word_end, frame_end;

    assign msb_idx   = BIT_W'(word_bits(wlen_code) - 6'd1);
    assign shift_idx = bit_cnt - BIT_W'(1);
    assign word_end  = (bit_cnt == '0);
    assign frame_end = word_end && (word_cnt == frame_len);
    assign next_word = hold_full ? hold_data : cur_word;
    assign take      = load_word && hold_full;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    // Next state and transition actions
    always_comb begin
        state_n     = state_q;
        start_frame = 1'b0;
        load_word   = 1'b0;
        first_load  = 1'b0;
        do_shift    = 1'b0;
        go_quiet    = 1'b0;
        abort_frame = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (enable) state_n = ST_WAIT;
            end
            ST_WAIT: begin
                if (tick && fs_start) start_frame = 1'b1;
            end
            ST_DELAY: begin
                if (tick) begin
                    if (fs_start && !ign_fs) begin
                        abort_frame = 1'b1;
                    end else begin
                        load_word  = 1'b1;
                        first_load = 1'b1;
                        state_n    = ST_SHIFT;
                    end
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (frame_end) begin
                        if (fs_start) begin
                            start_frame = 1'b1;
                        end else begin
                            go_quiet = 1'b1;
                            state_n  = ST_WAIT;
                        end
                    end else if (fs_start && !ign_fs) begin
                        abort_frame = 1'b1;
                    end else if (word_end) begin
                        load_word = 1'b1;
                    end else begin
                        do_shift = 1'b1;
                    end
                end
            end
            default: state_n = ST_OFF;
        endcase
        if (abort_frame) begin
            state_n = ST_WAIT;
        end
        if (start_frame) begin
            if (delay_on) begin
                state_n  = ST_DELAY;
                go_quiet = 1'b1;
            end else begin
                state_n    = ST_SHIFT;
                load_word  = 1'b1;
                first_load = 1'b1;
            end
        end
        if (!enable) begin
            state_n     = ST_OFF;
            start_frame = 1'b0;
            load_word   = 1'b0;
            first_load  = 1'b0;
            do_shift    = 1'b0;
            go_quiet    = 1'b0;
            abort_frame = 1'b0;
        end
    end

    // Outputs and shifter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdata       <= 1'b0;
            cur_word    <= '0;
            bit_cnt     <= '0;
            word_cnt    <= '0;
            sync_err    <= 1'b0;
            underrun    <= 1'b0;
            slot_pulse  <= 1'b0;
            frame_pulse <= 1'b0;
        end else if (!enable) begin
            sdata       <= 1'b0;
            cur_word    <= '0;
            bit_cnt     <= '0;
            word_cnt    <= '0;
            sync_err    <= 1'b0;
            underrun    <= 1'b0;
            slot_pulse  <= 1'b0;
            frame_pulse <= 1'b0;
        end else begin
            slot_pulse  <= load_word;
            frame_pulse <= start_frame;
            if (load_word) begin
                cur_word <= next_word;
                bit_cnt  <= msb_idx;
                word_cnt <= first_load ? '0 : FRLEN_W'(word_cnt + 1'b1);
                sdata    <= next_word[msb_idx];
                if (!hold_full) underrun <= 1'b1;
            end else if (do_shift) begin
                bit_cnt <= shift_idx;
                sdata   <= cur_word[shift_idx];
            end else if (go_quiet || abort_frame) begin
                sdata <= 1'b0;
            end
            if (abort_frame) sync_err <= 1'b1;
        end
    end

endmodule

// File: rtl/sat_tx.sv
module sat_tx
    import sat_pkg::*;
#(
    parameter int FRLEN_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic [2:0]          cfg_wlen,
    input  logic                cfg_delay,
    input  logic                cfg_clk_pol,
    input  logic [FRLEN_W-1:0]  cfg_frame_len,
    input  logic                cfg_ign_fs,
    input  logic [1:0]          cfg_req_mode,
    input  logic                bclk,
    input  logic                fsync,
    input  logic [WORD_MAX-1:0] in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                sdata,
    output logic                tx_req,
    output logic                sync_err,
    output logic                underrun
);

    logic tick, fs_start, take, hold_full, slot_pulse, frame_pulse;
    logic [WORD_MAX-1:0] hold_data;

    sat_bit_timing u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (tx_en),
        .clk_pol  (cfg_clk_pol),
        .bclk     (bclk),
        .fsync    (fsync),
        .tick     (tick),
        .fs_start (fs_start)
    );

    sat_hold_reg #(.WORD_W(WORD_MAX)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (tx_en),
        .in_valid (in_valid),
        .in_data  (in_data),
        .take     (take),
        .in_ready (in_ready),
        .full     (hold_full),
        .data     (hold_data)
    );

    sat_tx_fsm #(.FRLEN_W(FRLEN_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (tx_en),
        .wlen_code   (cfg_wlen),
        .delay_on    (cfg_delay),
        .frame_len   (cfg_frame_len),
        .ign_fs      (cfg_ign_fs),
        .tick        (tick),
        .fs_start    (fs_start),
        .hold_full   (hold_full),
        .hold_data   (hold_data),
        .take        (take),
        .sdata       (sdata),
        .sync_err    (sync_err),
        .underrun    (underrun),
        .slot_pulse  (slot_pulse),
        .frame_pulse (frame_pulse)
    );

    always_comb begin
        unique case (req_mode_e'(cfg_req_mode))
            REQ_EMPTY:   tx_req = in_ready;
            REQ_SLOT:    tx_req = slot_pulse;
            REQ_FRAME:   tx_req = frame_pulse;
            REQ_SYNCERR: tx_req = sync_err;
            default:     tx_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/sat_tx_checker.sv
module sat_tx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic [1:0] cfg_req_mode,
    input logic       in_valid,
    input logic       in_ready,
    input logic       sdata,
    input logic       tx_req,
    input logic       sync_err,
    input logic       underrun
);

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!sdata && !sync_err && !underrun));

    assert_ready_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !in_ready);

    assert_accept_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && tx_en) |=> sync_err);

    assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> !sdata);

    assert_urun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && tx_en) |=> underrun);

    assert_frame_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_mode == 2'd2 && tx_req) |=> (cfg_req_mode != 2'd2 || !tx_req));

endmodule

bind sat_tx sat_tx_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_en),
    .cfg_req_mode (cfg_req_mode),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .sdata        (sdata),
    .tx_req       (tx_req),
    .sync_err     (sync_err),
    .underrun     (underrun)
);

// File: tb/tb_sat_tx.sv
`timescale 1ns/1ps
module tb_sat_tx;

    localparam int FRLEN_W = 3;
    localparam int NV = 6;
    localparam int V_WL [NV]  = '{2, 0, 1, 3, 4, 5};
    localparam int V_DLY[NV]  = '{1, 0, 1, 0, 1, 0};
    localparam int V_POL[NV]  = '{0, 1, 1, 0, 0, 1};
    localparam int V_FL [NV]  = '{1, 1, 0, 2, 1, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic [2:0] cfg_wlen = '0;
    logic cfg_delay = 1'b0, cfg_clk_pol = 1'b0, cfg_ign_fs = 1'b0;
    logic [FRLEN_W-1:0] cfg_frame_len = '0;
    logic [1:0] cfg_req_mode = '0;
    logic bclk = 1'b0, fsync = 1'b0, in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic in_ready, sdata, tx_req, sync_err, underrun;

    int n_checks = 0, n_fail = 0;
    int pol = 0, push_idx = 0, push_cnt = 0;
    bit done = 0;
    logic [31:0] wbuf [8];

    always #4 clk = ~clk;

    sat_tx #(.FRLEN_W(FRLEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cfg_wlen(cfg_wlen),
        .cfg_delay(cfg_delay), .cfg_clk_pol(cfg_clk_pol),
        .cfg_frame_len(cfg_frame_len), .cfg_ign_fs(cfg_ign_fs),
        .cfg_req_mode(cfg_req_mode), .bclk(bclk), .fsync(fsync),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .sdata(sdata), .tx_req(tx_req), .sync_err(sync_err), .underrun(underrun)
    );

    function automatic int code_bits(input int c);
        case (c)
            0: return 8;
            1: return 12;
            2: return 16;
            3: return 20;
            4: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic void fill(input int seed);
        for (int k = 0; k < 8; k++)
            wbuf[k] = 32'hA5C3_9E17 ^ (32'h1357_9BDF * (k + 1)) ^ (32'h0F0F_0101 * seed);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic setup(input int wl, input int dly, input int pl, input int fl,
                         input int ign, input int mode);
        @(negedge clk);
        tx_en = 1'b0; in_valid = 1'b0; fsync = 1'b0;
        cfg_wlen = 3'(wl); cfg_delay = 1'(dly); cfg_clk_pol = 1'(pl);
        cfg_frame_len = FRLEN_W'(fl); cfg_ign_fs = 1'(ign); cfg_req_mode = 2'(mode);
        pol = pl;
        bclk = (pl != 0);
        repeat (2) @(negedge clk);
        tx_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One bit slot: active edge, then inactive edge with optional word push.
    task automatic tick_bit(input logic fs, output logic sd, output logic rq);
        @(negedge clk);
        in_valid = 1'b0;
        bclk = (pol == 0);
        fsync = fs;
        @(negedge clk);
        sd = sdata;
        rq = tx_req;
        bclk = (pol != 0);
        if (push_idx < push_cnt && in_ready) begin
            in_valid = 1'b1;
            in_data = wbuf[push_idx];
            push_idx++;
        end
    endtask

    task automatic prepush(input int supply);
        push_idx = 0;
        push_cnt = supply;
        @(negedge clk);
        in_valid = 1'b0;
        if (push_idx < push_cnt && in_ready) begin
            in_valid = 1'b1;
            in_data = wbuf[push_idx];
            push_idx++;
        end
    endtask

    task automatic run_frame(input int nw, input int bits, input int dly, input int supply,
                             input int fs_extra, input bit trailing, input string tag);
        int bad = 0, fj = 0, k, b;
        logic sd, rq, ex, fa = 1'b0, fe = 1'b0;
        logic [31:0] w;
        prepush(supply);
        for (int j = 0; j < dly + nw * bits; j++) begin
            tick_bit((j == 0) || (j == fs_extra), sd, rq);
            if (dly != 0 && j == 0) begin
                ex = 1'b0;
            end else begin
                k = (j - dly) / bits;
                b = bits - 1 - ((j - dly) % bits);
                w = (k < supply) ? wbuf[k] : wbuf[supply - 1];
                ex = w[b];
            end
            if (sd !== ex) begin
                if (bad == 0) begin fj = j; fa = sd; fe = ex; end
                bad++;
            end
        end
        if (trailing) begin
            tick_bit(1'b0, sd, rq);
            if (sd !== 1'b0) begin
                if (bad == 0) begin fj = dly + nw * bits; fa = sd; fe = 1'b0; end
                bad++;
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s: %0d bad slots, first slot %0d actual=%b expected=%b",
                     tag, bad, fj, fa, fe);
        end
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic sd, rq;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R9, R10 mode 0 follows in_ready)
        chk(sdata == 1'b0 && sync_err == 1'b0 && underrun == 1'b0, "R9 reset flags",
            {29'd0, sdata, sync_err, underrun}, 32'd0);
        chk(in_ready == 1'b0 && tx_req == 1'b0, "R10 reset request", {30'd0, in_ready, tx_req}, 32'd0);

        // Vector table: R1 lengths, R2 delay, R3 polarity, R4 frame length
        for (int v = 0; v < NV; v++) begin
            setup(V_WL[v], V_DLY[v], V_POL[v], V_FL[v], 0, 0);
            fill(v);
            run_frame(V_FL[v] + 1, code_bits(V_WL[v]), V_DLY[v], V_FL[v] + 1, -1, 1'b1,
                      $sformatf("R1 R2 R3 R4 vector %0d", v));
            chk(sync_err == 1'b0 && underrun == 1'b0, "R4 clean frame flags",
                {30'd0, sync_err, underrun}, 32'd0);
        end

        // Handshake and request mode 0 (R5, R10)
        setup(0, 0, 0, 1, 0, 0);
        chk(in_ready == 1'b1 && tx_req == 1'b1, "R5 ready when empty", {30'd0, in_ready, tx_req}, 32'h3);
        fill(9);
        prepush(1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0 && tx_req == 1'b0, "R5 full after accept", {30'd0, in_ready, tx_req}, 32'd0);

        // Underrun: only one word supplied to a two-word frame (R6)
        setup(0, 0, 0, 1, 0, 0);
        fill(11);
        run_frame(2, 8, 0, 1, -1, 1'b1, "R6 repeated word");
        chk(underrun == 1'b1, "R6 underrun flag", {31'd0, underrun}, 32'd1);

        // Unexpected sync with error enabled (R7, R10 mode 3)
        setup(2, 1, 0, 1, 0, 3);
        fill(12);
        prepush(1);
        tick_bit(1'b1, sd, rq);
        tick_bit(1'b0, sd, rq);
        tick_bit(1'b0, sd, rq);
        tick_bit(1'b1, sd, rq);
        chk(sd == 1'b0 && sync_err == 1'b1, "R7 abort on early sync", {30'd0, sd, sync_err}, 32'h1);
        chk(rq == 1'b1, "R10 mode 3 follows error", {31'd0, rq}, 32'd1);
        tick_bit(1'b0, sd, rq);
        chk(sd == 1'b0 && sync_err == 1'b1, "R7 quiet and sticky", {30'd0, sd, sync_err}, 32'h1);
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(sync_err == 1'b0, "R9 disable clears error", {31'd0, sync_err}, 32'd0);

        // Ignored early sync (R8)
        setup(2, 1, 0, 1, 1, 0);
        fill(13);
        run_frame(2, 16, 1, 2, 6, 1'b1, "R8 ignored sync frame");
        chk(sync_err == 1'b0, "R8 no error when ignored", {31'd0, sync_err}, 32'd0);

        // Back-to-back frames (R11)
        setup(0, 0, 0, 0, 0, 0);
        fill(14);
        run_frame(1, 8, 0, 1, -1, 1'b0, "R11 first frame");
        fill(15);
        run_frame(1, 8, 0, 1, -1, 1'b1, "R11 chained frame");
        chk(sync_err == 1'b0, "R11 no error on chained sync", {31'd0, sync_err}, 32'd0);

        // Request mode 2 frame pulse (R10)
        setup(0, 1, 0, 1, 0, 2);
        fill(16);
        prepush(2);
        tick_bit(1'b1, sd, rq);
        chk(rq == 1'b1, "R10 mode 2 pulse at start", {31'd0, rq}, 32'd1);
        tick_bit(1'b0, sd, rq);
        chk(rq == 1'b0, "R10 mode 2 pulse ends", {31'd0, rq}, 32'd0);

        // Request mode 1 slot pulse (R10)
        setup(0, 1, 0, 1, 0, 1);
        fill(17);
        prepush(2);
        tick_bit(1'b1, sd, rq);
        chk(rq == 1'b0, "R10 mode 1 quiet in delay", {31'd0, rq}, 32'd0);
        tick_bit(1'b0, sd, rq);
        chk(rq == 1'b1, "R10 mode 1 pulse at load", {31'd0, rq}, 32'd1);

        // Disabled block ignores inputs (R9)
        setup(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        tx_en = 1'b0;
        in_valid = 1'b1;
        in_data = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            bclk = ~bclk;
            fsync = ~fsync;
        end
        @(negedge clk);
        chk(sdata == 1'b0 && in_ready == 1'b0, "R9 off ignores bclk and data",
            {30'd0, sdata, in_ready}, 32'd0);
        in_valid = 1'b0;
        fsync = 1'b0;
        bclk = 1'b0;
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 nothing held after off", {31'd0, in_ready}, 32'd1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule